// File: doc/BRIEF.md
# Paired Charge-Transfer Balancing Sequencer

This block schedules charge transfers in a string of four series batteries that share a balance bus with a fifth buffer battery. A free-running monitoring timer fires a tick once every configured interval. At each tick, while the block is idle, it takes a snapshot of the five voltage readings. On the following cycle it picks the highest and the lowest of the four batteries. A transfer starts when the spread between those two is too wide, or when the buffer battery has sagged below its floor.

A transfer always moves charge between two channels. The source channel's discharge enable and the receiver channel's charge enable take turns, one switching tick each, so the two halves run in anti-phase. The transfer runs for a configured number of switching ticks. At every monitoring tick during the transfer, the live battery readings are compared with a safety window, and a reading outside that window stops the transfer at once. After a stop the block stays quiet for a full monitoring interval before it evaluates again. Measurement, statistics and host access sit outside this block, and all settings arrive as plain configuration inputs.

Top module: `pair_balance_seq`

## Requirements
- R1: Channel i (0 to 3 for the batteries, 4 for the buffer) is read from `meas_v[i*VW +: VW]` and drives bit i of `dis_en` and `chg_en`. A monitoring tick fires every `cfg_interval` cycles (a value of 0 acts as 1). While idle, each tick snapshots the readings and evaluates them on the next cycle, so a condition that persists restarts transfers every two intervals when a transfer is longer than one interval and shorter than two.
- R2: If the highest battery minus the lowest battery is strictly greater than `cfg_gap_thr`, a transfer starts on the cycle after evaluation. The highest battery is the source and the lowest battery is the receiver.
- R3: If no battery pair qualifies and the buffer reading (channel 4) is strictly below `cfg_buf_low`, a transfer starts with the highest battery as the source and the buffer as the receiver (`chg_en` bit 4).
- R4: `xfer_active` stays high for exactly `cfg_duration` switching ticks of `cfg_tick_len` cycles each. A value of 0 in either setting acts as 1.
- R5: During a transfer only the source's `dis_en` bit is high in the first switching tick, only the receiver's `chg_en` bit is high in the next one, and the two keep alternating. A discharge enable and a charge enable are never high in the same cycle.
- R6: When two or more batteries tie for the highest or the lowest reading, the one with the lower channel index is selected.
- R7: When neither the spread condition nor the buffer condition holds, no transfer starts and all enables stay low.
- R8: During a transfer, at each monitoring tick, any battery 0 to 3 reading strictly above `cfg_safe_hi` or strictly below `cfg_safe_lo` ends the transfer on the next cycle. The buffer reading is not compared with these limits.
- R9: After a transfer is stopped by a limit, the block stays quiet until the next monitoring tick and then idles until the tick after that. If the trigger is still present, the next transfer therefore begins 2·`cfg_interval`+1 cycles after the stop.
- R10: If any battery in the snapshot lies outside the safety window, no transfer starts.
- R11: While reset is held and after it is released, `dis_en`, `chg_en` and `xfer_active` are all zero until a transfer is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_v | input | (NB+1)*VW | Packed voltage readings, channel i at bits i*VW upward, buffer last |
| cfg_interval | input | IW | Monitoring interval in cycles |
| cfg_tick_len | input | TW | Switching tick length in cycles |
| cfg_duration | input | DW | Transfer length in switching ticks |
| cfg_gap_thr | input | VW | Spread above which a battery pair is balanced |
| cfg_buf_low | input | VW | Buffer floor that triggers a refill |
| cfg_safe_hi | input | VW | Upper battery safety limit |
| cfg_safe_lo | input | VW | Lower battery safety limit |
| dis_en | output | NB+1 | Per-channel discharge phase enable |
| chg_en | output | NB+1 | Per-channel charge phase enable |
| xfer_active | output | 1 | High while a transfer runs |

## Verification
The embedded properties check the following on every cycle:
- The enables are one-hot at most and never overlap.
- The phases swap at each switching-tick boundary and hold steady between boundaries.
- A limit crossing seen at a monitoring tick moves the block to the stopped state.
- The stopped state persists until the next tick.
- Each evaluation outcome leads to the right kind of transfer.

The choice of which channel pairs with which, tie-breaking, exact transfer lengths under several duration and tick settings, the restart spacing, and the exclusion of the buffer from the safety check only show up in the bench's scenarios. The bench runs a sweep of every combination of four reading levels on each battery with a high and a low buffer, plus directed stop cases.

// File: rtl/pair_balance_seq.sv
module pair_balance_seq #(
  parameter int NB = 4,
  parameter int VW = 12,
  parameter int IW = 16,
  parameter int TW = 8,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [(NB+1)*VW-1:0] meas_v,
  input  logic [IW-1:0]        cfg_interval,
  input  logic [TW-1:0]        cfg_tick_len,
  input  logic [DW-1:0]        cfg_duration,
  input  logic [VW-1:0]        cfg_gap_thr,
  input  logic [VW-1:0]        cfg_buf_low,
  input  logic [VW-1:0]        cfg_safe_hi,
  input  logic [VW-1:0]        cfg_safe_lo,
  output logic [NB:0]          dis_en,
  output logic [NB:0]          chg_en,
  output logic                 xfer_active
);

  localparam int NCH = NB + 1;
  localparam int CW  = $clog2(NCH);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_XFER, S_ABORT} st_t;

  st_t                 state;
  logic [IW-1:0]       ivl_cnt;
  logic [TW-1:0]       tick_cnt;
  logic [DW-1:0]       dur_cnt;
  logic [NCH*VW-1:0]   snap;
  logic [CW-1:0]       src, dst;
  logic                phase;

  logic [IW-1:0] ivl_eff;
  logic [TW-1:0] tl_eff;
  logic [DW-1:0] dur_eff;
  logic          mon_tick, tick_end, dur_last;

  assign ivl_eff  = (cfg_interval == '0) ? IW'(1) : cfg_interval;
  assign tl_eff   = (cfg_tick_len == '0) ? TW'(1) : cfg_tick_len;
  assign dur_eff  = (cfg_duration == '0) ? DW'(1) : cfg_duration;
  assign mon_tick = ivl_cnt >= ivl_eff - IW'(1);
  assign tick_end = tick_cnt >= tl_eff - TW'(1);
  assign dur_last = dur_cnt >= dur_eff - DW'(1);

  logic [CW-1:0] hi_i, lo_i;
  logic [VW-1:0] hi_v, lo_v, buf_v;
  logic          snap_bad, live_bad;

  always_comb begin
    logic [VW-1:0] cv;
    hi_i = '0;
    lo_i = '0;
    hi_v = snap[0 +: VW];
    lo_v = snap[0 +: VW];
    snap_bad = 1'b0;
    for (int i = 0; i < NB; i++) begin
      cv = snap[i*VW +: VW];
      if (cv > hi_v) begin hi_v = cv; hi_i = CW'(i); end
      if (cv < lo_v) begin lo_v = cv; lo_i = CW'(i); end
      if (cv > cfg_safe_hi || cv < cfg_safe_lo) snap_bad = 1'b1;
    end
  end

  always_comb begin
    logic [VW-1:0] lv;
    live_bad = 1'b0;
    for (int i = 0; i < NB; i++) begin
      lv = meas_v[i*VW +: VW];
      if (lv > cfg_safe_hi || lv < cfg_safe_lo) live_bad = 1'b1;
    end
  end

  assign buf_v = snap[NB*VW +: VW];

  logic pair_gap, buf_need, stop_now;
  assign pair_gap = (hi_v - lo_v) > cfg_gap_thr;
  assign buf_need = buf_v < cfg_buf_low;
  assign stop_now = mon_tick && live_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) ivl_cnt <= '0;
    else        ivl_cnt <= mon_tick ? '0 : ivl_cnt + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      snap     <= '0;
      src      <= '0;
      dst      <= '0;
      phase    <= 1'b0;
      tick_cnt <= '0;
      dur_cnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (mon_tick) begin
          snap  <= meas_v;
          state <= S_EVAL;
        end
        S_EVAL: begin
          phase    <= 1'b0;
          tick_cnt <= '0;
          dur_cnt  <= '0;
          if (snap_bad) state <= S_ABORT;
          else if (pair_gap) begin
            src <= hi_i; dst <= lo_i; state <= S_XFER;
          end else if (buf_need) begin
            src <= hi_i; dst <= CW'(NB); state <= S_XFER;
          end else state <= S_IDLE;
        end
        S_XFER: begin
          if (stop_now) state <= S_ABORT;
          else if (tick_end) begin
            tick_cnt <= '0;
            phase    <= ~phase;
            dur_cnt  <= dur_cnt + DW'(1);
            if (dur_last) state <= S_IDLE;
          end else tick_cnt <= tick_cnt + TW'(1);
        end
        S_ABORT: if (mon_tick) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign xfer_active = (state == S_XFER);
  assign dis_en = (xfer_active && !phase) ? (NCH'(1) << src) : '0;
  assign chg_en = (xfer_active &&  phase) ? (NCH'(1) << dst) : '0;

  AST_ENABLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dis_en) && $onehot0(chg_en) && !(|dis_en && |chg_en)); // R5
  AST_SWAP_TO_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    (|dis_en && tick_end && !dur_last && !stop_now) |=> |chg_en); // R5
  AST_SWAP_TO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg_en && tick_end && !dur_last && !stop_now) |=> |dis_en); // R5
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !tick_end && !stop_now) |=> ($stable(dis_en) && $stable(chg_en))); // R4
  AST_DUR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (dur_cnt < dur_eff)); // R4
  AST_PAIR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && !snap_bad && pair_gap) |=> (xfer_active && src != dst && dst != CW'(NB))); // R2
  AST_BUF_RECEIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && !snap_bad && !pair_gap && buf_need) |=> (xfer_active && dst == CW'(NB))); // R3
  AST_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && !pair_gap && !buf_need) |=> !xfer_active); // R7
  AST_LIMIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && stop_now) |=> (state == S_ABORT)); // R8
  AST_SNAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL && snap_bad) |=> !xfer_active); // R10
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ABORT && !mon_tick) |=> (state == S_ABORT)); // R9

endmodule

// File: tb/sim_pair_balance_seq.sv
module sim_pair_balance_seq;
  localparam int NB = 4, VW = 12, IW = 16, TW = 8, DW = 16;
  localparam int IV = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [VW-1:0] v [0:NB];
  logic [(NB+1)*VW-1:0] meas_v;
  logic [IW-1:0] cfg_interval;
  logic [TW-1:0] cfg_tick_len;
  logic [DW-1:0] cfg_duration;
  logic [VW-1:0] cfg_gap_thr, cfg_buf_low, cfg_safe_hi, cfg_safe_lo;
  logic [NB:0] dis_en, chg_en;
  logic xfer_active;

  assign meas_v = {v[4], v[3], v[2], v[1], v[0]};

  pair_balance_seq #(.NB(NB), .VW(VW), .IW(IW), .TW(TW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .meas_v(meas_v),
    .cfg_interval(cfg_interval), .cfg_tick_len(cfg_tick_len), .cfg_duration(cfg_duration),
    .cfg_gap_thr(cfg_gap_thr), .cfg_buf_low(cfg_buf_low),
    .cfg_safe_hi(cfg_safe_hi), .cfg_safe_lo(cfg_safe_lo),
    .dis_en(dis_en), .chg_en(chg_en), .xfer_active(xfer_active));

  int checks = 0, fails = 0;
  bit done = 0;
  int tl_now = 2, len_now = 10;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_all(input int a, input int b, input int c, input int d, input int bf);
    v[0] = VW'(a); v[1] = VW'(b); v[2] = VW'(c); v[3] = VW'(d); v[4] = VW'(bf);
  endtask

  task automatic wait_rise(output bit seen);
    seen = 0;
    for (int k = 0; k < 3*IV + 2; k++) begin
      @(negedge clk);
      if (xfer_active) begin seen = 1; break; end
    end
  endtask

  task automatic track(input int src, input int dst, input int inj_ch, input int inj_val,
                       output int len, output int bad);
    len = 0; bad = 0;
    while (xfer_active) begin
      int ph;
      logic [NB:0] ed, ec;
      ph = (len / tl_now) % 2;
      ed = (ph == 0) ? (5'd1 << src) : 5'd0;
      ec = (ph == 1) ? (5'd1 << dst) : 5'd0;
      if (dis_en !== ed || chg_en !== ec) bad++;
      if (len == 1 && inj_ch >= 0) v[inj_ch] = VW'(inj_val);
      len++;
      if (len > 1000) break;
      @(negedge clk);
    end
  endtask

  task automatic quiesce();
    set_all(100, 100, 100, 100, 150);
    while (xfer_active) @(negedge clk);
    repeat (2*IV + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    int len, bad, cnt;
    rst_n = 1'b0;
    cfg_interval = IW'(IV); cfg_tick_len = 2; cfg_duration = 5;
    cfg_gap_thr = 15; cfg_buf_low = 95; cfg_safe_hi = 200; cfg_safe_lo = 50;
    set_all(100, 100, 100, 100, 150);
    repeat (3) @(negedge clk);
    chk(dis_en == 0 && chg_en == 0 && !xfer_active, "R11", "outputs in reset", int'({dis_en, chg_en, xfer_active}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dis_en == 0 && chg_en == 0 && !xfer_active, "R11", "outputs after reset", int'({dis_en, chg_en, xfer_active}), 0);

    // Sweep: four levels per battery, buffer high or low (R1, R2, R3, R5, R6, R7)
    for (int p = 0; p < 256; p++) begin
      for (int b = 0; b < 2; b++) begin
        int vals [0:3];
        int hi, lo, exs, exd;
        hi = 0; lo = 0;
        for (int i = 0; i < 4; i++) begin
          vals[i] = 100 + 8*((p >> (2*i)) & 3);
          v[i] = VW'(vals[i]);
          if (vals[i] > vals[hi]) hi = i;
          if (vals[i] < vals[lo]) lo = i;
        end
        v[4] = (b == 1) ? VW'(90) : VW'(150);
        exs = -1; exd = -1;
        if (vals[hi] - vals[lo] > 15) begin exs = hi; exd = lo; end
        else if (b == 1) begin exs = hi; exd = 4; end
        if (exs >= 0) begin
          wait_rise(seen);
          chk(seen, (exd == 4) ? "R3" : "R2", "transfer start", int'(seen), 1);
          if (seen) begin
            track(exs, exd, -1, 0, len, bad);
            chk(bad == 0, "R5/R6", "enable pattern mismatches", bad, 0);
            chk(len == 10, "R4", "transfer length", len, 10);
          end
        end else begin
          cnt = 0;
          repeat (2*IV + 4) begin @(negedge clk); if (xfer_active || dis_en != 0 || chg_en != 0) cnt++; end
          chk(cnt == 0, "R7", "active cycles with no trigger", cnt, 0);
        end
      end
    end

    // R1: persistent trigger restarts every two intervals
    quiesce();
    set_all(124, 100, 100, 100, 150);
    wait_rise(seen);
    cnt = 0;
    while (xfer_active && cnt < 100) begin @(negedge clk); cnt++; end
    while (!xfer_active && cnt < 100) begin @(negedge clk); cnt++; end
    chk(cnt == 2*IV, "R1", "start-to-start spacing", cnt, 2*IV);

    // R8 high limit stop, then R9 restart spacing
    quiesce();
    set_all(124, 100, 100, 100, 150);
    wait_rise(seen);
    track(0, 1, 2, 210, len, bad);
    chk(len == IV - 1, "R8", "length with high limit crossed", len, IV - 1);
    v[2] = 100;
    cnt = 1;
    while (!xfer_active && cnt < 100) begin @(negedge clk); if (!xfer_active) cnt++; end
    chk(cnt == 2*IV + 1, "R9", "quiet cycles after stop", cnt, 2*IV + 1);

    // R8 low limit stop
    quiesce();
    set_all(100, 124, 100, 100, 150);
    wait_rise(seen);
    track(1, 0, 3, 40, len, bad);
    chk(len == IV - 1, "R8", "length with low limit crossed", len, IV - 1);
    chk(bad == 0, "R5", "pattern before stop", bad, 0);

    // R8 buffer not limit-checked
    quiesce();
    set_all(100, 100, 100, 124, 150);
    wait_rise(seen);
    track(3, 0, 4, 250, len, bad);
    chk(len == 10, "R8", "length with buffer above limit", len, 10);

    // R10 out-of-window battery blocks start
    quiesce();
    set_all(40, 130, 100, 100, 90);
    cnt = 0;
    repeat (4*IV) begin @(negedge clk); if (xfer_active) cnt++; end
    chk(cnt == 0, "R10", "active cycles with unsafe snapshot", cnt, 0);

    // R4 other duration and tick settings, zero acting as one
    for (int c = 0; c < 3; c++) begin
      int dd, tt, el;
      dd = (c == 0) ? 3 : (c == 1) ? 0 : 1;
      tt = (c == 0) ? 3 : (c == 1) ? 0 : 4;
      el = ((dd == 0) ? 1 : dd) * ((tt == 0) ? 1 : tt);
      quiesce();
      cfg_duration = DW'(dd); cfg_tick_len = TW'(tt);
      tl_now = (tt == 0) ? 1 : tt;
      set_all(100, 100, 130, 108, 150);
      wait_rise(seen);
      track(2, 0, -1, 0, len, bad);
      chk(len == el, "R4", "length for setting", len, el);
      chk(bad == 0, "R5", "pattern for setting", bad, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule